// File: doc/BRIEF.md
# Core Warm Reset Handshake Controller

This block runs the warm reset request of one processor core as a four-phase handshake. Software starts a request by writing the request bit. The controller then raises its warm reset request and drops its active indication. It waits until the core reports both its request-n line and its state line high. It then answers with accept, or with deny when an abort has been signalled during the wait. The answer is held until the core lowers both handshake lines. The controller then returns to idle and raises the active indication again.

An accepted request ends with a one-cycle completion pulse to the reset status logic. The pulse carries a reset type code and a reset source code. A denied request produces no pulse. A request bit written while a handshake is in flight is not queued. It sets a sticky rejected flag. The two core handshake inputs pass through a synchroniser whose depth is a parameter (zero bypasses it).

States: IDLE (active high, nothing requested), WAIT (request high, active low, waiting for the core), ACCEPT (accept high), DENY (deny high). Transitions: IDLE to WAIT on a request write; WAIT to ACCEPT when both core inputs are high and no abort is pending; WAIT to DENY when both are high and an abort is pending; ACCEPT or DENY to IDLE when both core inputs are low.

Top module: `warm_rst_hs`

## Requirements
- R1: After reset the controller is in IDLE with warm_req_o=0, core_active_o=1, accept_o=0, deny_o=0, done_o=0, done_type_o=0, done_src_o=0 and rejected_o=0.
- R2: A cycle with wr_en_i=1 and wr_req_bit_i=1 in IDLE sets warm_req_o=1 and core_active_o=0 together at the next clock edge. A write with wr_req_bit_i=0 has no effect.
- R3: In WAIT the controller answers only when the synchronised core_preq_n_i and core_pstate_i are both high. One of them high alone never produces an answer. The answer appears SYNC_STAGES+1 edges after both inputs go high.
- R4: The answer is accept_o=1 if abort_i was low in every WAIT cycle. It is deny_o=1 if abort_i was high in any WAIT cycle, the deciding cycle included. accept_o and deny_o are never high together.
- R5: accept_o or deny_o, with warm_req_o, stays high until both synchronised core inputs are low. At that edge the controller goes to IDLE: warm_req_o=0, accept_o=0, deny_o=0, core_active_o=1.
- R6: Leaving ACCEPT gives done_o=1 for exactly one cycle, during the first IDLE cycle, with done_type_o=3 (2 bits) and done_src_o=5 (3 bits). Leaving DENY gives no pulse. Both codes read 0 whenever done_o=0.
- R7: A request write outside IDLE is ignored and not queued. It sets rejected_o, which stays high until reset.
- R8: warm_req_o rises only from a cycle in which accept_o and deny_o are both low and the previous request has been released. After a return to IDLE, a new write starts a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_req_bit_i | input | 1 | Value of the request bit in the write |
| abort_i | input | 1 | Abort control; high selects deny |
| core_preq_n_i | input | 1 | Core request-n handshake line |
| core_pstate_i | input | 1 | Core state handshake line |
| warm_req_o | output | 1 | Warm reset request to the core |
| core_active_o | output | 1 | Active indication to the core |
| accept_o | output | 1 | Request accepted |
| deny_o | output | 1 | Request denied |
| done_o | output | 1 | One-cycle completion pulse |
| done_type_o | output | TYPE_W | Reset type code, valid with done_o |
| done_src_o | output | SRC_W | Reset source code, valid with done_o |
| rejected_o | output | 1 | Sticky flag for a request refused while busy |

## Verification
The bench builds the block with its defaults: SYNC_STAGES=2, TYPE_W=2, SRC_W=3, type code 3 and source code 5. The two-stage synchroniser puts a three-edge latency between a core input change and the answer, and the bench checks the exact edge. It sweeps three abort cases: none, a one-cycle abort early in the wait, and an abort raised together with the deciding inputs. Each case covers partial handshakes in both phases, a busy write, and a zero-bit write in IDLE, so every transition and the sticky flag's persistence across requests are reached.

// File: rtl/wrh_pkg.sv
package wrh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACCEPT = 2'd2,
        ST_DENY   = 2'd3
    } wrh_state_e;
endpackage

// File: rtl/wrh_sync.sv
module wrh_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] pipe [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign q_o = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/wrh_fsm.sv
module wrh_fsm
    import wrh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    input  logic preq_n_s,
    input  logic pstate_s,
    output logic idle_o,
    output logic finish_acc_o,
    output logic warm_req_o,
    output logic active_o,
    output logic accept_o,
    output logic deny_o
);
    wrh_state_e state_q, state_d;
    logic       abort_pend_q;
    logic       both_hi, both_lo;

    assign both_hi = preq_n_s && pstate_s;
    assign both_lo = !preq_n_s && !pstate_s;

    // state register and abort capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            abort_pend_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            abort_pend_q <= (state_q == ST_WAIT) ? (abort_pend_q | abort_i) : 1'b0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_WAIT;
            ST_WAIT:   if (both_hi) state_d = (abort_pend_q || abort_i) ? ST_DENY : ST_ACCEPT;
            ST_ACCEPT: if (both_lo) state_d = ST_IDLE;
            ST_DENY:   if (both_lo) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        warm_req_o = 1'b0;
        active_o   = 1'b0;
        accept_o   = 1'b0;
        deny_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:   active_o = 1'b1;
            ST_WAIT:   warm_req_o = 1'b1;
            ST_ACCEPT: begin warm_req_o = 1'b1; accept_o = 1'b1; end
            ST_DENY:   begin warm_req_o = 1'b1; deny_o   = 1'b1; end
            default:   active_o = 1'b1;
        endcase
    end

    assign idle_o       = (state_q == ST_IDLE);
    assign finish_acc_o = (state_q == ST_ACCEPT) && both_lo;

    // R2: request and active never high together
    a_r2_req_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
        warm_req_o |-> !active_o);
    // R3: an answer only follows both synchronised inputs high
    a_r3_answer_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(accept_o) || $rose(deny_o)) |-> $past(both_hi));
    // R4: accept and deny exclusive
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && deny_o));
    // R5: answer held while the core keeps any handshake line high
    a_r5_hold_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !both_lo) |=> accept_o);
    // R8: re-arm only after release with accept and deny low
    a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warm_req_o) |-> ($past(!accept_o && !deny_o && !warm_req_o)));
endmodule

// File: rtl/wrh_report.sv
module wrh_report #(
    parameter int TYPE_W    = 2,
    parameter int SRC_W     = 3,
    parameter int TYPE_CODE = 3,
    parameter int SRC_CODE  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish_acc_i,
    input  logic              start_i,
    input  logic              idle_i,
    output logic              done_o,
    output logic [TYPE_W-1:0] done_type_o,
    output logic [SRC_W-1:0]  done_src_o,
    output logic              rejected_o
);
    logic done_q, rej_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            rej_q  <= 1'b0;
        end else begin
            done_q <= finish_acc_i;
            rej_q  <= rej_q | (start_i && !idle_i);
        end
    end

    assign done_o      = done_q;
    assign done_type_o = done_q ? TYPE_W'(TYPE_CODE) : '0;
    assign done_src_o  = done_q ? SRC_W'(SRC_CODE)   : '0;
    assign rejected_o  = rej_q;

    // R7: the rejected flag is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rej_q |=> rej_q);
    // R6: completion pulse lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/warm_rst_hs.sv
module warm_rst_hs #(
    parameter int SYNC_STAGES = 2,
    parameter int TYPE_W      = 2,
    parameter int SRC_W       = 3,
    parameter int TYPE_CODE   = 3,
    parameter int SRC_CODE    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_req_bit_i,
    input  logic              abort_i,
    input  logic              core_preq_n_i,
    input  logic              core_pstate_i,
    output logic              warm_req_o,
    output logic              core_active_o,
    output logic              accept_o,
    output logic              deny_o,
    output logic              done_o,
    output logic [TYPE_W-1:0] done_type_o,
    output logic [SRC_W-1:0]  done_src_o,
    output logic              rejected_o
);
    logic       start;
    logic [1:0] hs_sync;
    logic       idle, finish_acc;

    assign start = wr_en_i && wr_req_bit_i;

    wrh_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({core_preq_n_i, core_pstate_i}),
        .q_o   (hs_sync)
    );

    wrh_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .abort_i      (abort_i),
        .preq_n_s     (hs_sync[1]),
        .pstate_s     (hs_sync[0]),
        .idle_o       (idle),
        .finish_acc_o (finish_acc),
        .warm_req_o   (warm_req_o),
        .active_o     (core_active_o),
        .accept_o     (accept_o),
        .deny_o       (deny_o)
    );

    wrh_report #(
        .TYPE_W    (TYPE_W),
        .SRC_W     (SRC_W),
        .TYPE_CODE (TYPE_CODE),
        .SRC_CODE  (SRC_CODE)
    ) u_report (
        .clk          (clk),
        .rst_n        (rst_n),
        .finish_acc_i (finish_acc),
        .start_i      (start),
        .idle_i       (idle),
        .done_o       (done_o),
        .done_type_o  (done_type_o),
        .done_src_o   (done_src_o),
        .rejected_o   (rejected_o)
    );

    // R6: a completion pulse only follows an accept
    a_r6_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(accept_o));
endmodule

// File: tb/warm_rst_hs_bench.sv
module warm_rst_hs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_bit = 1'b0, abort = 1'b0;
    logic       preq_n = 1'b0, pstate = 1'b0;
    logic       warm_req, active, accept, deny, done, rejected;
    logic [1:0] dtype;
    logic [2:0] dsrc;
    int         total = 0, bad = 0;

    always #4 clk = ~clk;

    warm_rst_hs u_warm_rst_hs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_req_bit_i(wr_bit),
        .abort_i(abort), .core_preq_n_i(preq_n), .core_pstate_i(pstate),
        .warm_req_o(warm_req), .core_active_o(active), .accept_o(accept),
        .deny_o(deny), .done_o(done), .done_type_o(dtype), .done_src_o(dsrc),
        .rejected_o(rejected)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // packs {warm_req, active, accept, deny}
    function automatic int hs_vec();
        return {warm_req, active, accept, deny};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 handshake", hs_vec(), 4'b0100);
        chk("R1 done", {done, dtype, dsrc}, 0);
        chk("R1 rejected", rejected, 0);

        for (int a = 0; a < 3; a++) begin
            chk("R7 sticky across requests", rejected, (a > 0) ? 1 : 0);
            // R2 start
            wr_en = 1'b1; wr_bit = 1'b1;
            step(1);
            wr_en = 1'b0; wr_bit = 1'b0;
            chk("R2 request with active low", hs_vec(), 4'b1000);
            // R3 partial handshake: request-n only
            preq_n = 1'b1; pstate = 1'b0;
            if (a == 1) begin
                abort = 1'b1; step(1); abort = 1'b0; step(3);
            end else step(4);
            chk("R3 one input not enough", hs_vec(), 4'b1000);
            // R7 busy write
            wr_en = 1'b1; wr_bit = 1'b1;
            step(1);
            wr_en = 1'b0; wr_bit = 1'b0;
            chk("R7 rejected set", rejected, 1);
            chk("R7 busy write ignored", hs_vec(), 4'b1000);
            // R3/R4 decision
            preq_n = 1'b1; pstate = 1'b1;
            if (a == 2) abort = 1'b1;
            step(2);
            chk("R3 latency not before stages+1", hs_vec(), 4'b1000);
            step(1);
            abort = 1'b0;
            chk("R4 answer", hs_vec(), (a == 0) ? 4'b1010 : 4'b1001);
            // R5 hold
            step(3);
            chk("R5 held", hs_vec(), (a == 0) ? 4'b1010 : 4'b1001);
            preq_n = 1'b0;
            step(3);
            chk("R5 held with one line high", hs_vec(), (a == 0) ? 4'b1010 : 4'b1001);
            chk("R6 no early pulse", done, 0);
            pstate = 1'b0;
            step(2);
            chk("R5 held before sync", hs_vec(), (a == 0) ? 4'b1010 : 4'b1001);
            step(1);
            chk("R5 back to idle", hs_vec(), 4'b0100);
            chk("R6 pulse", done, (a == 0) ? 1 : 0);
            chk("R6 type code", dtype, (a == 0) ? 3 : 0);
            chk("R6 source code", dsrc, (a == 0) ? 5 : 0);
            step(1);
            chk("R6 one cycle", {done, dtype, dsrc}, 0);
            // R2 zero-bit write ignored
            wr_en = 1'b1; wr_bit = 1'b0;
            step(1);
            wr_en = 1'b0;
            chk("R2 zero bit ignored", hs_vec(), 4'b0100);
            chk("R8 idle rearm ready", {accept, deny}, 0);
        end
        // R8 new request after completion
        wr_en = 1'b1; wr_bit = 1'b1;
        step(1);
        wr_en = 1'b0; wr_bit = 1'b0;
        chk("R8 new request starts", hs_vec(), 4'b1000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule